// File: doc/BRIEF.md
# AES-128 Round Key Expander

This block turns a 128-bit cipher key into the full sequence of 44 32-bit round key words that an AES-128 encryption datapath uses. The first four words feed the key addition before the first round. Each later group of four words feeds one of the ten rounds. A single-cycle start pulse captures the key. The block then streams one word per clock, each with a valid strobe and its word index, so a consumer can write the words into its own storage or use them on the fly.

Words are produced by a serial recurrence over a four-word sliding window. At the start of each round group, the previous word is rotated by one byte, passed through four combinational S-box instances and mixed with a round constant. The S-box is computed as a GF(2^8) inverse followed by the affine transform, so no table is loaded from outside. The round constant lives in an 8-bit register that is doubled in GF(2^8) after each use.

Top module: `kx_aes128_expand`

## Requirements
- R1: The clock edge after an accepted start begins the output: `rk_valid_o` is high for exactly 44 consecutive cycles, and `rk_idx_o` runs 0, 1, ..., 43 in that order without gaps.
- R2: Words 0 to 3 equal the key in column order: word 0 is `key_i[127:96]`, word 1 is `key_i[95:64]`, word 2 is `key_i[63:32]`, word 3 is `key_i[31:0]`.
- R3: For an index i from 5 to 43 that is not a multiple of 4, word i equals word i-1 XOR word i-4.
- R4: For an index i that is a multiple of 4 and at least 4, word i equals word i-4 XOR the round constant XOR the S-box applied to each byte of word i-1 rotated left by 8 bits.
- R5: The round constant used for index 4j (j = 1..10) has bits 23:0 zero, and its bits 31:24 take the values 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 in that order. These are obtained by repeated doubling modulo x^8+x^4+x^3+x+1.
- R6: The S-box maps a byte to its multiplicative inverse in GF(2^8), with 0 mapped to 0, and then applies the affine transform with constant 0x63. For example, byte 0x00 maps to 0x63, so an all-zero key gives word 4 = 0x62636363.
- R7: A start pulse that arrives while words are still being produced has no effect: the current word sequence continues unchanged to index 43, and the new key is not taken.
- R8: `done_o` rises one cycle after the cycle in which word 43 is presented. It stays high until the next accepted start, which clears it at the same edge. It is never high together with `rk_valid_o`.
- R9: After reset, `rk_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures `key_i` when the block is not busy |
| key_i | input | NK*32 (128) | Cipher key, word 0 in the top 32 bits |
| rk_valid_o | output | 1 | High while `rk_word_o` carries a round key word |
| rk_idx_o | output | IDX_W (6) | Index of the word on `rk_word_o`, 0 to 43 |
| rk_word_o | output | 32 | Round key word |
| done_o | output | 1 | Set after the last word; cleared by the next accepted start |

## Verification
The bench builds the block with its default parameters: NK = 4 and NR = 10, giving 44 words and a 6-bit index. That configuration is small enough to compare every word of every expansion against a reference built in the bench from a log/antilog S-box and a literal round constant list. A sweep of keys covers the all-zero key (it reaches S-box input 0), the all-ones key, the standard test key with its published final word b6630ca6, and a walking-one pattern across every byte lane, so that all ten round constants and many S-box inputs are used. Start pulses in the middle of a run and immediately after done check the ignore and restart rules.

// File: rtl/kx_aes_pkg.sv
package kx_aes_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int WORD_BYTES = WORD_W / BYTE_W;

    // multiply by x modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // a^254 equals the inverse for nonzero a, and 0 for a = 0
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] pw;
        logic [7:0] res;
        pw  = a;
        res = 8'h01;
        for (int k = 1; k < 8; k++) begin
            pw  = gf_mul(pw, pw);
            res = gf_mul(res, pw);
        end
        return res;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] affine63(input logic [7:0] x);
        return x ^ rotl8(x, 1) ^ rotl8(x, 2) ^ rotl8(x, 3) ^ rotl8(x, 4) ^ 8'h63;
    endfunction

endpackage

// File: rtl/kx_sbox.sv
module kx_sbox
    import kx_aes_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] inv_s;

    always_comb begin
        inv_s  = gf_inv(byte_i);
        byte_o = affine63(inv_s);
    end
endmodule

// File: rtl/kx_sub_word.sv
module kx_sub_word
    import kx_aes_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] word_o
);
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        kx_sbox u_sbox (
            .byte_i (word_i[g*BYTE_W +: BYTE_W]),
            .byte_o (word_o[g*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/kx_next_word.sv
module kx_next_word
    import kx_aes_pkg::*;
(
    input  logic [WORD_W-1:0] prev_i,
    input  logic [WORD_W-1:0] back_i,
    input  logic [BYTE_W-1:0] rcon_i,
    input  logic              group_head_i,
    output logic [WORD_W-1:0] next_o
);
    logic [WORD_W-1:0] rot_s;
    logic [WORD_W-1:0] sub_s;
    logic [WORD_W-1:0] mix_s;

    assign rot_s = {prev_i[WORD_W-BYTE_W-1:0], prev_i[WORD_W-1 -: BYTE_W]};

    kx_sub_word u_sub (
        .word_i (rot_s),
        .word_o (sub_s)
    );

    always_comb begin
        if (group_head_i) begin
            mix_s = sub_s ^ {rcon_i, {(WORD_W-BYTE_W){1'b0}}};
        end else begin
            mix_s = prev_i;
        end
        next_o = mix_s ^ back_i;
    end
endmodule

// File: rtl/kx_aes128_expand.sv
module kx_aes128_expand
    import kx_aes_pkg::*;
#(
    parameter int NK    = 4,
    parameter int NR    = 10,
    parameter int TOTAL = NK * (NR + 1),
    parameter int IDX_W = $clog2(TOTAL)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [NK*WORD_W-1:0] key_i,
    output logic                 rk_valid_o,
    output logic [IDX_W-1:0]     rk_idx_o,
    output logic [WORD_W-1:0]    rk_word_o,
    output logic                 done_o
);
    localparam int LAST = TOTAL - 1;
    localparam int GRP_W = $clog2(NK);

    typedef struct packed {
        logic                      busy;
        logic                      done;
        logic [IDX_W-1:0]          idx;
        logic [BYTE_W-1:0]         rcon;
        logic [NK-1:0][WORD_W-1:0] win;
        logic                      out_valid;
        logic [IDX_W-1:0]          out_idx;
        logic [WORD_W-1:0]         out_word;
    } kx_state_t;

    kx_state_t st_d, st_q;

    logic [WORD_W-1:0] gen_word_s;
    logic              group_head_s;
    logic              key_phase_s;

    assign key_phase_s  = (st_q.idx < IDX_W'(NK));
    assign group_head_s = (st_q.idx[GRP_W-1:0] == '0);

    kx_next_word u_next (
        .prev_i       (st_q.win[NK-1]),
        .back_i       (st_q.win[0]),
        .rcon_i       (st_q.rcon),
        .group_head_i (group_head_s),
        .next_o       (gen_word_s)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;

        if (st_q.out_valid && st_q.out_idx == IDX_W'(LAST)) begin
            st_d.done = 1'b1;
        end

        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.done = 1'b0;
                st_d.idx  = '0;
                st_d.rcon = 8'h01;
                for (int k = 0; k < NK; k++) begin
                    st_d.win[k] = key_i[(NK-1-k)*WORD_W +: WORD_W];
                end
            end
        end else begin
            st_d.out_valid = 1'b1;
            st_d.out_idx   = st_q.idx;
            for (int k = 0; k < NK-1; k++) begin
                st_d.win[k] = st_q.win[k+1];
            end
            if (key_phase_s) begin
                st_d.out_word     = st_q.win[0];
                st_d.win[NK-1]    = st_q.win[0];
            end else begin
                st_d.out_word     = gen_word_s;
                st_d.win[NK-1]    = gen_word_s;
                if (group_head_s) begin
                    st_d.rcon = gf_dbl(st_q.rcon);
                end
            end
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx == IDX_W'(LAST)) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rk_valid_o = st_q.out_valid;
    assign rk_idx_o   = st_q.out_idx;
    assign rk_word_o  = st_q.out_word;
    assign done_o     = st_q.done;

endmodule

// File: rtl/kx_expand_chk.sv
module kx_expand_chk #(
    parameter int TOTAL = 44,
    parameter int IDX_W = 6
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             rk_valid_o,
    input logic [IDX_W-1:0] rk_idx_o,
    input logic [31:0]      rk_word_o,
    input logic             done_o
);
    logic [3:0][31:0] hist_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hist_q <= '0;
        end else if (rk_valid_o) begin
            hist_q <= {hist_q[2:0], rk_word_o};
        end
    end

    assert_first_idx_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rk_valid_o) |-> rk_idx_o == '0);

    assert_idx_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rk_valid_o && rk_idx_o != '0) |-> ($past(rk_valid_o) && rk_idx_o == $past(rk_idx_o) + 1'b1));

    assert_xor_chain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rk_valid_o && rk_idx_o > IDX_W'(4) && rk_idx_o[1:0] != 2'b00)
            |-> rk_word_o == (hist_q[0] ^ hist_q[3]));

    assert_run_continues_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rk_valid_o && rk_idx_o != IDX_W'(TOTAL-1)) |=> (rk_valid_o && !$rose(rk_idx_o == '0)));

    assert_done_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rk_valid_o && rk_idx_o == IDX_W'(TOTAL-1) && !start_i) |=> done_o);

    assert_done_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> done_o);

    assert_done_not_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && rk_valid_o));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            assert_reset_quiet_R9: assert (!rk_valid_o && !done_o);
        end
    end
endmodule

bind kx_aes128_expand kx_expand_chk #(.TOTAL(TOTAL), .IDX_W(IDX_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rk_valid_o (rk_valid_o),
    .rk_idx_o   (rk_idx_o),
    .rk_word_o  (rk_word_o),
    .done_o     (done_o)
);

// File: tb/tb_kx_aes128_expand.sv
module tb_kx_aes128_expand;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key = '0;
    logic         valid;
    logic [5:0]   idx;
    logic [31:0]  word;
    logic         done;

    int checks = 0;
    int errors = 0;

    logic [7:0]  sb [256];
    logic [31:0] exp_w [44];

    always #5 clk = ~clk;

    kx_aes128_expand dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .key_i      (key),
        .rk_valid_o (valid),
        .rk_idx_o   (idx),
        .rk_word_o  (word),
        .done_o     (done)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] xt(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    endfunction

    // S-box from log/antilog tables with generator 3
    task automatic build_sbox();
        logic [7:0] ex [256];
        int         lg [256];
        logic [7:0] e;
        logic [7:0] inv;
        logic [7:0] r;
        e = 8'h01;
        for (int i = 0; i < 255; i++) begin
            ex[i] = e;
            lg[e] = i;
            e = e ^ xt(e);
        end
        for (int a = 0; a < 256; a++) begin
            inv = (a == 0) ? 8'h00 : ex[(255 - lg[a]) % 255];
            for (int b = 0; b < 8; b++) begin
                r[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8] ^ ((8'h63 >> b) & 1);
            end
            sb[a] = r;
        end
    endtask

    task automatic build_ref(input logic [127:0] k);
        logic [7:0]  rc [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
        logic [31:0] t;
        for (int i = 0; i < 4; i++) exp_w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = exp_w[i-1];
            if (i % 4 == 0) begin
                t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc[i/4-1], 24'h0};
            end
            exp_w[i] = t ^ exp_w[i-4];
        end
    endtask

    // one full expansion; optional disturbing start mid-run (R7)
    task automatic run_key(input logic [127:0] k, input logic poke);
        build_ref(k);
        @(negedge clk);
        key   = k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 44; n++) begin
            @(negedge clk);
            start = 1'b0;
            chk(valid === 1'b1, "R1 valid", {31'd0, valid}, 32'd1);
            chk(idx == 6'(n), "R1 index", {26'd0, idx}, n);
            if (n < 4)
                chk(word == exp_w[n], "R2 key word", word, exp_w[n]);
            else if (n % 4 != 0)
                chk(word == exp_w[n], "R3 chained word", word, exp_w[n]);
            else
                chk(word == exp_w[n], "R4 R5 R6 group head word", word, exp_w[n]);
            chk(done === 1'b0, "R8 done low during run", {31'd0, done}, 32'd0);
            if (poke && n == 20) begin
                key   = ~k;
                start = 1'b1;
            end
        end
        @(negedge clk);
        key = '0;
        chk(valid === 1'b0, "R1 exactly 44 words", {31'd0, valid}, 32'd0);
        chk(done === 1'b1, "R8 done after last", {31'd0, done}, 32'd1);
        repeat (3) @(negedge clk);
        chk(done === 1'b1 && valid === 1'b0, "R8 done holds R7 no restart", {30'd0, done, valid}, 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        build_sbox();
        repeat (3) @(negedge clk);
        chk(valid === 1'b0 && done === 1'b0, "R9 reset state", {30'd0, valid, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid === 1'b0 && done === 1'b0, "R9 idle after reset", {30'd0, valid, done}, 32'd0);

        run_key(128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b0);
        chk(exp_w[43] == 32'hb6630ca6, "R4 reference anchor", exp_w[43], 32'hb6630ca6);

        run_key(128'h0, 1'b0);
        chk(exp_w[4] == 32'h62636363, "R6 zero byte maps to 63", exp_w[4], 32'h62636363);
        chk(exp_w[43] == 32'h6f8f188e, "R6 zero key anchor", exp_w[43], 32'h6f8f188e);

        run_key({128{1'b1}}, 1'b0);
        run_key(128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b1);

        for (int b = 0; b < 16; b++) begin
            run_key(128'h1 << (8*b + (b % 8)), b[0]);
        end
        for (int b = 0; b < 4; b++) begin
            run_key({16{8'(b*37 + 11)}}, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule